// File: doc/BRIEF.md
# Splittable Reload Timer with Capture

This block is a 16-bit up-counter that reloads from a pair of reload registers when it wraps. A split control bit turns it into two independent 8-bit reload counters, a low byte and a high byte, each with its own reload value. The low byte keeps running in split mode whatever the run bit says, while the run bit still gates the high byte. Two sticky overflow flags record wraps and drive an interrupt request. A capture mode lets the counter run freely and copies its value into the reload registers on each trigger event.

Count ticks come either from the system clock or from an external tick. Each byte has its own select input for this choice. A two-bit source field picks the external tick from three sources: the system clock divided by 12, a comparator input, or a real-time-clock input divided by 8. The same field picks the capture trigger. Asynchronous inputs are synchronised and edge-detected before use. Software reaches the control byte, both count bytes and both reload bytes through a simple write strobe and a combinational read port.

Top module: `split_reload_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Address 0 is the control byte, 1 the count low byte, 2 the count high byte, 3 the reload low byte and 4 the reload high byte. A write with `wr_en` high stores `wr_data` at `addr`. `rd_data` shows the register at `addr` without delay. Control bits are: bit0 run, bit1 split, bit2 capture enable, bit3 low-byte interrupt enable, bits5:4 source select, bit6 low-byte overflow flag, bit7 high-byte overflow flag.
- R3: With split = 0 and run = 1, the 16-bit count {high,low} goes up by one on each low-side tick, and a low-byte carry goes into the high byte. The low-side tick is every cycle when `lo_sys_clk` = 1, and the external tick otherwise.
- R4: With split = 0 and capture off, a tick at 0xFFFF loads {reload high, reload low} and sets both flags.
- R5: With split = 0 and run = 0, the count holds.
- R6: With split = 1, the low byte counts on every low-side tick whatever the run bit says. On a tick at 0xFF it loads the reload low byte and sets the low flag. The high byte counts only when run = 1, on high-side ticks (`hi_sys_clk` or the external tick). On a tick at 0xFF it loads the reload high byte and sets the high flag.
- R7: The low flag is set on every low-byte wrap from 0xFF, in both modes, including the 16-bit full wrap.
- R8: Hardware never clears a flag. A control write sets both flags to the written bits 7:6. A hardware set in the same cycle takes priority.
- R9: `irq` = `irq_en` AND (high flag OR (low-byte interrupt enable AND low flag)).
- R10: The external tick depends on the select field: 00 and 10 give one pulse per 12 system cycles, 01 gives one pulse per synchronised comparator rising edge, and 11 gives one pulse per 8 synchronised real-time-clock rising edges.
- R11: With capture on, a wrapping counter goes to 0 instead of the reload value. The trigger is the divided real-time-clock tick for select 00/01 and the comparator rising edge for 10/11. Each trigger copies the current count into the reload registers and sets the high flag, whatever the run bit says.
- R12: A comparator rising edge raises the count on the third clock edge after the input changes, never sooner. One edge gives exactly one count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | BW | Write data |
| rd_data | output | BW | Read data of the addressed register |
| cmp_in | input | 1 | Asynchronous comparator signal |
| rtc_in | input | 1 | Asynchronous real-time-clock signal |
| lo_sys_clk | input | 1 | Low byte (and 16-bit counter) counts on the system clock when 1 |
| hi_sys_clk | input | 1 | High byte in split mode counts on the system clock when 1 |
| irq_en | input | 1 | Timer interrupt enable from the interrupt controller |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: an 8-bit byte, two synchroniser stages, a divide-by-12 system prescaler and a divide-by-8 real-time-clock prescaler. Because the byte is 8 bits, preloaded counts reach the 0xFF and 0xFFFF wraps within a few cycles. A 120-cycle window holds exactly ten divide-by-12 ticks whatever the prescaler phase. Sixteen real-time-clock edges after reset give exactly two divided ticks. With two synchroniser stages, the third-edge comparator latency can be checked exactly.

// File: rtl/srt_pkg.sv
package srt_pkg;

    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_CNT_LO = 3'd1,
        REG_CNT_HI = 3'd2,
        REG_RLD_LO = 3'd3,
        REG_RLD_HI = 3'd4
    } reg_addr_e;

    localparam int CB_RUN   = 0;
    localparam int CB_SPLIT = 1;
    localparam int CB_CAP   = 2;
    localparam int CB_LOIE  = 3;
    localparam int CB_SEL0  = 4;
    localparam int CB_SEL1  = 5;
    localparam int CB_LOF   = 6;
    localparam int CB_HIF   = 7;

endpackage

// File: rtl/srt_edge_sync.sv
module srt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q, sync_d;
    logic              last_q, last_d;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], async_in};
        last_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            last_q <= last_d;
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R12

endmodule

// File: rtl/srt_pulse_div.sv
module srt_pulse_div #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_pulse,
    output logic out_pulse
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    assign out_pulse = in_pulse && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (in_pulse) cnt_d = out_pulse ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_pulse |=> !out_pulse); // R10

endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer
    import srt_pkg::*;
#(
    parameter int BW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SYS_DIV     = 12,
    parameter int RTC_DIV     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    addr,
    input  logic [BW-1:0] wr_data,
    output logic [BW-1:0] rd_data,
    input  logic          cmp_in,
    input  logic          rtc_in,
    input  logic          lo_sys_clk,
    input  logic          hi_sys_clk,
    input  logic          irq_en,
    output logic          irq
);
    localparam int CW = 2 * BW;

    typedef struct packed {
        logic [BW-1:0] lo;
        logic [BW-1:0] hi;
        logic [BW-1:0] rlo;
        logic [BW-1:0] rhi;
        logic          run;
        logic          split;
        logic          cap;
        logic          loie;
        logic [1:0]    sel;
        logic          lof;
        logic          hif;
    } state_t;

    state_t s_q, s_d;

    logic cmp_rise, rtc_rise, rtc_tick, sys_tick;
    logic ext_tick, trig, lo_tick, hi_tick;
    logic wr_ctrl, wr_lo, wr_hi, wr_rlo, wr_rhi;
    logic lo_set, hi_set;
    logic [CW-1:0] cnt_full;

    srt_edge_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cmp_in), .rise(cmp_rise));
    srt_edge_sync #(.STAGES(SYNC_STAGES)) u_rtc_sync (
        .clk(clk), .rst_n(rst_n), .async_in(rtc_in), .rise(rtc_rise));
    srt_pulse_div #(.DIV(RTC_DIV)) u_rtc_div (
        .clk(clk), .rst_n(rst_n), .in_pulse(rtc_rise), .out_pulse(rtc_tick));
    srt_pulse_div #(.DIV(SYS_DIV)) u_sys_div (
        .clk(clk), .rst_n(rst_n), .in_pulse(1'b1), .out_pulse(sys_tick));

    always_comb begin
        case (s_q.sel)
            2'b01:   ext_tick = cmp_rise;
            2'b11:   ext_tick = rtc_tick;
            default: ext_tick = sys_tick;
        endcase
        trig    = s_q.sel[1] ? cmp_rise : rtc_tick;
        lo_tick = lo_sys_clk | ext_tick;
        hi_tick = hi_sys_clk | ext_tick;
    end

    assign wr_ctrl  = wr_en && (addr == REG_CTRL);
    assign wr_lo    = wr_en && (addr == REG_CNT_LO);
    assign wr_hi    = wr_en && (addr == REG_CNT_HI);
    assign wr_rlo   = wr_en && (addr == REG_RLD_LO);
    assign wr_rhi   = wr_en && (addr == REG_RLD_HI);
    assign cnt_full = {s_q.hi, s_q.lo};

    always_comb begin
        s_d    = s_q;
        lo_set = 1'b0;
        hi_set = 1'b0;
        if (!s_q.split) begin
            if (s_q.run && lo_tick) begin
                if (&s_q.lo) lo_set = 1'b1;
                if (&cnt_full) begin
                    hi_set = 1'b1;
                    {s_d.hi, s_d.lo} = s_q.cap ? '0 : {s_q.rhi, s_q.rlo};
                end else begin
                    {s_d.hi, s_d.lo} = cnt_full + 1'b1;
                end
            end
        end else begin
            if (lo_tick) begin
                if (&s_q.lo) begin
                    lo_set = 1'b1;
                    s_d.lo = s_q.cap ? '0 : s_q.rlo;
                end else begin
                    s_d.lo = s_q.lo + 1'b1;
                end
            end
            if (s_q.run && hi_tick) begin
                if (&s_q.hi) begin
                    hi_set = 1'b1;
                    s_d.hi = s_q.cap ? '0 : s_q.rhi;
                end else begin
                    s_d.hi = s_q.hi + 1'b1;
                end
            end
        end
        if (s_q.cap && trig) begin
            s_d.rlo = s_q.lo;
            s_d.rhi = s_q.hi;
            hi_set  = 1'b1;
        end
        if (wr_ctrl) begin
            s_d.run   = wr_data[CB_RUN];
            s_d.split = wr_data[CB_SPLIT];
            s_d.cap   = wr_data[CB_CAP];
            s_d.loie  = wr_data[CB_LOIE];
            s_d.sel   = wr_data[CB_SEL1:CB_SEL0];
            s_d.lof   = wr_data[CB_LOF];
            s_d.hif   = wr_data[CB_HIF];
        end
        if (wr_lo)  s_d.lo  = wr_data;
        if (wr_hi)  s_d.hi  = wr_data;
        if (wr_rlo) s_d.rlo = wr_data;
        if (wr_rhi) s_d.rhi = wr_data;
        s_d.lof = s_d.lof | lo_set;
        s_d.hif = s_d.hif | hi_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (addr)
            REG_CTRL:   rd_data = BW'({s_q.hif, s_q.lof, s_q.sel, s_q.loie,
                                       s_q.cap, s_q.split, s_q.run});
            REG_CNT_LO: rd_data = s_q.lo;
            REG_CNT_HI: rd_data = s_q.hi;
            REG_RLD_LO: rd_data = s_q.rlo;
            REG_RLD_HI: rd_data = s_q.rhi;
            default:    rd_data = '0;
        endcase
    end

    assign irq = irq_en & (s_q.hif | (s_q.loie & s_q.lof));

    AST_FULL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.split && s_q.run && lo_tick && !s_q.cap && (&cnt_full) && !wr_lo && !wr_hi)
        |=> ({s_q.hi, s_q.lo} == $past({s_q.rhi, s_q.rlo}))); // R4

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.split && !s_q.run && !wr_lo && !wr_hi)
        |=> $stable({s_q.hi, s_q.lo})); // R5

    AST_LOW_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.split && lo_sys_clk && !(&s_q.lo) && !wr_lo)
        |=> (s_q.lo == $past(s_q.lo) + 1'b1)); // R6

    AST_HIF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.hif) |-> $past(wr_ctrl)); // R8

    AST_LOF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.lof) |-> $past(wr_ctrl)); // R8

    AST_CAPTURE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cap && trig) |=> s_q.hif); // R11

endmodule

// File: tb/split_reload_timer_tb.sv
module split_reload_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       cmp_in = 1'b0;
    logic       rtc_in = 1'b0;
    logic       lo_sys_clk = 1'b0;
    logic       hi_sys_clk = 1'b0;
    logic       irq_en = 1'b0;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    split_reload_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .cmp_in(cmp_in),
        .rtc_in(rtc_in), .lo_sys_clk(lo_sys_clk), .hi_sys_clk(hi_sys_clk),
        .irq_en(irq_en), .irq(irq));

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] lo;
        logic [7:0] hi;
        logic [7:0] rlo;
        logic [7:0] rhi;
        logic [7:0] cyc;
        logic [7:0] exp_lo;
        logic [7:0] exp_hi;
        logic [1:0] exp_flags;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h11, 8'hF0, 8'h12, 8'h00, 8'h00, 8'd5,  8'hF5, 8'h12, 2'b00}, // R3
        '{8'h11, 8'hFE, 8'h12, 8'h00, 8'h00, 8'd3,  8'h01, 8'h13, 2'b01}, // R3 R7
        '{8'h11, 8'hFE, 8'hFF, 8'h34, 8'hAB, 8'd3,  8'h35, 8'hAB, 2'b11}, // R4
        '{8'h10, 8'h55, 8'h66, 8'h00, 8'h00, 8'd10, 8'h55, 8'h66, 2'b00}, // R5
        '{8'h13, 8'hFE, 8'hFD, 8'h10, 8'h20, 8'd4,  8'h12, 8'h21, 2'b11}, // R6
        '{8'h12, 8'hFE, 8'hFD, 8'h10, 8'h20, 8'd4,  8'h12, 8'hFD, 2'b01}, // R6 R7
        '{8'h15, 8'hFF, 8'hFF, 8'h34, 8'hAB, 8'd2,  8'h01, 8'h00, 2'b11}, // R11
        '{8'h17, 8'h7F, 8'hFF, 8'h99, 8'h88, 8'd2,  8'h81, 8'h01, 2'b10}  // R11
    };

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
        addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s addr %0d got %h expected %h", req, a, rd_data, exp);
        end
    endtask

    task automatic irq_chk(input logic exp, input string req);
        #1;
        checks++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s irq got %b expected %b", req, irq, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(ref logic sig, input int n);
        for (int i = 0; i < n; i++) begin
            sig = 1'b1;
            repeat (2) @(negedge clk);
            sig = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        for (int a = 0; a < 5; a++) rd_chk(3'(a), 8'h00, "R1");
        irq_en = 1'b1;
        irq_chk(1'b0, "R1");
        irq_en = 1'b0;

        // R2 reload register read-back
        wr(3'd3, 8'h5A);
        rd_chk(3'd3, 8'h5A, "R2");
        wr(3'd4, 8'hA5);
        rd_chk(3'd4, 8'hA5, "R2");

        // vector table: R3 R4 R5 R6 R7 R11
        for (int v = 0; v < NV; v++) begin
            lo_sys_clk = 1'b0; hi_sys_clk = 1'b0;
            wr(3'd0, 8'h10);
            wr(3'd1, VECS[v].lo);
            wr(3'd2, VECS[v].hi);
            wr(3'd3, VECS[v].rlo);
            wr(3'd4, VECS[v].rhi);
            wr(3'd0, VECS[v].ctrl);
            lo_sys_clk = 1'b1; hi_sys_clk = 1'b1;
            repeat (int'(VECS[v].cyc)) @(negedge clk);
            lo_sys_clk = 1'b0; hi_sys_clk = 1'b0;
            rd_chk(3'd1, VECS[v].exp_lo, "R3/R4/R5/R6/R11 low");
            rd_chk(3'd2, VECS[v].exp_hi, "R3/R4/R5/R6/R11 high");
            rd_chk(3'd0, {VECS[v].exp_flags, VECS[v].ctrl[5:0]}, "R7 flags");
        end
        // R11 reload untouched by free-running capture wrap
        rd_chk(3'd3, 8'h99, "R11");

        // R8 flags sticky under idle cycles
        repeat (20) @(negedge clk);
        rd_chk(3'd0, 8'h97, "R8");

        // R9 interrupt combinations
        irq_en = 1'b1;
        wr(3'd0, 8'h40);
        irq_chk(1'b0, "R9");
        wr(3'd0, 8'h48);
        irq_chk(1'b1, "R9");
        wr(3'd0, 8'h80);
        irq_chk(1'b1, "R9");
        irq_en = 1'b0;
        irq_chk(1'b0, "R9");
        // R8 control write clears flag
        wr(3'd0, 8'h10);
        rd_chk(3'd0, 8'h10, "R8");

        // R10 system clock / 12
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h01);
        repeat (119) @(negedge clk);
        wr(3'd0, 8'h10);
        rd_chk(3'd1, 8'h0A, "R10 sys/12");
        rd_chk(3'd2, 8'h00, "R10 sys/12");

        // R12 comparator latency, then R10 comparator ticks
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h11);
        cmp_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd_chk(3'd1, 8'h00, "R12 early");
        @(negedge clk);
        rd_chk(3'd1, 8'h01, "R12 third edge");
        cmp_in = 1'b0;
        repeat (2) @(negedge clk);
        pulse(cmp_in, 5);
        repeat (4) @(negedge clk);
        rd_chk(3'd1, 8'h06, "R10 comparator");

        // R10 split, per-byte system select
        wr(3'd0, 8'h10);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h13);
        lo_sys_clk = 1'b1;
        repeat (6) @(negedge clk);
        lo_sys_clk = 1'b0;
        rd_chk(3'd1, 8'h06, "R10 split low");
        rd_chk(3'd2, 8'h00, "R10 split high");

        // R11 capture on comparator trigger
        wr(3'd0, 8'h10);
        wr(3'd1, 8'h34);
        wr(3'd2, 8'h12);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h24);
        pulse(cmp_in, 1);
        repeat (4) @(negedge clk);
        rd_chk(3'd3, 8'h34, "R11 capture low");
        rd_chk(3'd4, 8'h12, "R11 capture high");
        rd_chk(3'd0, 8'hA4, "R11 capture flag");

        // R10 real-time clock / 8
        do_reset();
        wr(3'd0, 8'h31);
        pulse(rtc_in, 16);
        repeat (4) @(negedge clk);
        rd_chk(3'd1, 8'h02, "R10 rtc/8");

        finish_run();
    end

endmodule